// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs one read or one write at a time on an asynchronous parallel memory bus for an 8-bit processor core. The core raises a request together with an address, write data and a direction bit. The sequencer then steps the bus through a fixed run of phases: a fixed overhead, an optional address-latch phase, address setup, the read or write strobe, and address hold. It ends with a one-cycle done pulse. Read data is returned with that pulse.

The length of each programmable phase is counted in system clock cycles and is held in a timing configuration register. The register also selects between two modes. In the plain mode the full address has dedicated pins. In the multiplexed mode the low address byte shares the data pins and is marked by a latch-enable pulse. On reset every timing field takes its slowest setting. The sequencer copies the configuration when it accepts a request, so the core can reprogram the timing at any moment without disturbing the transfer in flight.

Top module: `xmem_seq`

## Requirements
- R1: After reset the strobes are inactive (high), the latch enable, done and the data-pin output enable are low, and the timing fields hold their maximum values (setup 3, strobe code 15, hold 3, latch code 3) in plain mode. The first transfer then lasts 26 cycles with a 16-cycle strobe.
- R2: With setup field S, strobe code W and hold field H, a plain-mode transfer lasts 4+S+(W+1)+H cycles. Cycle 1 is the cycle after the clock edge that accepts the request, and the last cycle is the done cycle. The shortest plain-mode transfer is 5 cycles.
- R3: The strobe stays low for exactly W+1 cycles. The read strobe is used for reads and the write strobe for writes, and the two are never low together.
- R4: In multiplexed mode (mode bit 1) with latch code L, a latch phase of L+2 cycles precedes setup. During this phase the latch enable is high for the first L+1 cycles, and the data pins drive the low address byte with the output enable high. The address pins carry the high byte, and their low byte is held at zero. The shortest multiplexed transfer is 7 cycles.
- R5: In plain mode the latch enable never goes high.
- R6: In a write, the data pins drive the write data with the output enable high on every strobe cycle, and the address and data stay stable while the strobe is low.
- R7: In a read, the data-pin output enable stays low while the strobe is low. The value on the data input during the last strobe cycle is the read data shown with done.
- R8: Done is high for exactly one cycle, in the last cycle of the transfer.
- R9: A configuration write is accepted at any time, but it only affects transfers accepted after the write's clock edge. The transfer in progress keeps its timing.
- R10: A request is accepted only when no transfer is in progress. A request raised before the current transfer's done cycle ends starts nothing, and it does not alter the address, data or direction of the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the timing configuration fields below |
| cfg_mux | input | 1 | 1 = multiplexed mode, 0 = plain mode |
| cfg_latch | input | 2 | Latch code L (latch phase L+2 cycles) |
| cfg_setup | input | 2 | Address setup cycles S |
| cfg_strobe | input | 4 | Strobe code W (strobe W+1 cycles) |
| cfg_hold | input | 2 | Address hold cycles H |
| req | input | 1 | Transfer request, sampled only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 8 | Read data, valid with done |
| mem_addr | output | 16 | Address pins |
| mem_dout | output | 8 | Data pins, outgoing value |
| mem_doe | output | 1 | Data pin output enable |
| mem_din | input | 8 | Data pins, incoming value |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_ale | output | 1 | Address latch enable |

## Verification
The assertions check several properties on every cycle. The two strobes never overlap, and the latch enable is never high in plain mode or together with a strobe. The data pins are never driven under a read strobe, and write data and address stay stable under the write strobe. Every strobe pulse has the programmed width, every done is a single cycle, and the cycle count from acceptance to done matches the snapshotted timing. Other behaviours can only be shown by the bench's scenarios: the reset defaults, the read data captured on the last strobe cycle, the low address byte delivered through the latch phase, a configuration write landing in the middle of a transfer, and requests raised while the bus is busy.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  localparam int SETUP_W = 2;
  localparam int STRB_W  = 4;
  localparam int HOLD_W  = 2;
  localparam int LAT_W   = 2;
  localparam int OVH_PRE = 3;   // overhead cycles before the first phase; the done cycle adds one more
  localparam int CNT_W   = STRB_W + 1;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OVH, PH_LATCH, PH_SETUP, PH_STROBE, PH_HOLD, PH_DONE
  } phase_e;

  typedef struct packed {
    logic              mux;
    logic [LAT_W-1:0]   latch;
    logic [SETUP_W-1:0] setup;
    logic [STRB_W-1:0]  strobe;
    logic [HOLD_W-1:0]  hold;
  } tcfg_t;

  localparam tcfg_t TCFG_RESET = '{mux: 1'b0, latch: '1, setup: '1, strobe: '1, hold: '1};

  // Cycles spent in a phase, minus one (the counter's load value).
  function automatic logic [CNT_W-1:0] phase_len_m1(phase_e ph, tcfg_t c);
    case (ph)
      PH_OVH:    return CNT_W'(OVH_PRE - 1);
      PH_LATCH:  return CNT_W'(c.latch) + CNT_W'(1);
      PH_SETUP:  return CNT_W'(c.setup) - CNT_W'(1);
      PH_STROBE: return CNT_W'(c.strobe);
      PH_HOLD:   return CNT_W'(c.hold) - CNT_W'(1);
      default:   return '0;
    endcase
  endfunction

  // Phase that follows ph; zero-length phases are skipped.
  function automatic phase_e next_phase(phase_e ph, tcfg_t c);
    case (ph)
      PH_OVH:    return c.mux ? PH_LATCH : ((c.setup != '0) ? PH_SETUP : PH_STROBE);
      PH_LATCH:  return (c.setup != '0) ? PH_SETUP : PH_STROBE;
      PH_SETUP:  return PH_STROBE;
      PH_STROBE: return (c.hold != '0) ? PH_HOLD : PH_DONE;
      PH_HOLD:   return PH_DONE;
      default:   return PH_IDLE;
    endcase
  endfunction

  // Total cycles from acceptance to the done cycle inclusive.
  function automatic int unsigned xfer_cycles(tcfg_t c);
    int unsigned n;
    n = (OVH_PRE + 1) + int'(c.setup) + int'(c.strobe) + 1 + int'(c.hold);
    if (c.mux) n = n + int'(c.latch) + 2;
    return n;
  endfunction

endpackage

// File: rtl/xmem_cfg_reg.sv
module xmem_cfg_reg
  import xmem_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  tcfg_t wr_cfg,
  output tcfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= TCFG_RESET;
    else if (wr_en) cfg_q <= wr_cfg;
  end

endmodule

// File: rtl/xmem_phase_fsm.sv
module xmem_phase_fsm
  import xmem_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  tcfg_t  act_cfg,
  output phase_e phase,
  output logic   phase_last
);

  logic [CNT_W-1:0] cnt;
  phase_e           nxt_ph;
  logic [CNT_W-1:0] nxt_len;

  assign phase_last = (cnt == '0);

  always_comb begin
    nxt_ph  = next_phase(phase, act_cfg);
    nxt_len = phase_len_m1(nxt_ph, act_cfg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase <= PH_OVH;
        cnt   <= phase_len_m1(PH_OVH, act_cfg);
      end
    end else if (!phase_last) begin
      cnt <= cnt - CNT_W'(1);
    end else begin
      phase <= nxt_ph;
      cnt   <= nxt_len;
    end
  end

endmodule

// File: rtl/xmem_pin_drv.sv
module xmem_pin_drv
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              phase_last,
  input  logic              act_mux,
  input  logic              act_we,
  input  logic [ADDR_W-1:0] act_addr,
  input  logic [DATA_W-1:0] act_wdata,
  input  logic              rd_capture,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              mem_ale,
  output logic [DATA_W-1:0] rdata
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic in_latch;
  logic in_data_win;

  assign in_latch    = (phase == PH_LATCH);
  assign in_data_win = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);

  assign mem_addr = act_mux ? {act_addr[ADDR_W-1:DATA_W], {DATA_W{1'b0}}} : act_addr;
  assign mem_ale  = in_latch && !phase_last;
  assign mem_dout = in_latch ? act_addr[DATA_W-1:0] : act_wdata;
  assign mem_doe  = in_latch || (act_we && in_data_win);
  assign mem_rd_n = !((phase == PH_STROBE) && !act_we);
  assign mem_wr_n = !((phase == PH_STROBE) && act_we);

  always_ff @(posedge clk) begin
    if (!rst_n)          rdata <= '0;
    else if (rd_capture) rdata <= mem_din;
  end

  if (HI_W < 1) begin : g_bad_widths
    initial $error("address must be wider than data");
  end

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_mux,
  input  logic [1:0]        cfg_latch,
  input  logic [1:0]        cfg_setup,
  input  logic [3:0]        cfg_strobe,
  input  logic [1:0]        cfg_hold,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              mem_ale
);

  tcfg_t             wr_cfg;
  tcfg_t             cfg_q;
  tcfg_t             act_cfg;
  logic              act_we;
  logic [ADDR_W-1:0] act_addr;
  logic [DATA_W-1:0] act_wdata;
  phase_e            phase;
  logic              phase_last;

  // Named events, used by the bound checker.
  logic accept;
  logic rd_capture;

  assign wr_cfg = '{mux: cfg_mux, latch: cfg_latch, setup: cfg_setup,
                    strobe: cfg_strobe, hold: cfg_hold};

  assign accept     = req && (phase == PH_IDLE);
  assign rd_capture = (phase == PH_STROBE) && phase_last && !act_we;
  assign done       = (phase == PH_DONE);

  xmem_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_cfg (wr_cfg),
    .cfg_q  (cfg_q)
  );

  // Snapshot of the request and timing, fixed for the whole transfer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cfg   <= TCFG_RESET;
      act_we    <= 1'b0;
      act_addr  <= '0;
      act_wdata <= '0;
    end else if (accept) begin
      act_cfg   <= cfg_q;
      act_we    <= req_we;
      act_addr  <= req_addr;
      act_wdata <= req_wdata;
    end
  end

  xmem_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .act_cfg    (act_cfg),
    .phase      (phase),
    .phase_last (phase_last)
  );

  xmem_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .phase_last (phase_last),
    .act_mux    (act_cfg.mux),
    .act_we     (act_we),
    .act_addr   (act_addr),
    .act_wdata  (act_wdata),
    .rd_capture (rd_capture),
    .mem_din    (mem_din),
    .mem_addr   (mem_addr),
    .mem_dout   (mem_dout),
    .mem_doe    (mem_doe),
    .mem_rd_n   (mem_rd_n),
    .mem_wr_n   (mem_wr_n),
    .mem_ale    (mem_ale),
    .rdata      (rdata)
  );

endmodule

// File: rtl/xmem_seq_chk.sv
module xmem_seq_chk
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input tcfg_t             act_cfg,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dout,
  input logic              mem_doe,
  input logic              mem_rd_n,
  input logic              mem_wr_n,
  input logic              mem_ale
);

  logic [STRB_W+1:0] low_cnt;
  logic [7:0]        xfer_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     low_cnt <= '0;
    else if (!mem_rd_n || !mem_wr_n) low_cnt <= low_cnt + 1'b1;
    else                            low_cnt <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             xfer_cnt <= '0;
    else if (accept)        xfer_cnt <= 8'd1;
    else if (done)          xfer_cnt <= '0;
    else if (xfer_cnt != 0) xfer_cnt <= xfer_cnt + 8'd1;
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_n && mem_wr_n && low_cnt != '0) |-> (int'(low_cnt) == int'(act_cfg.strobe) + 1));

  assert_latch_drives_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ale |-> (mem_doe && mem_rd_n && mem_wr_n));

  assert_no_latch_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ale |-> act_cfg.mux);

  assert_write_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n && $past(!mem_wr_n)) |-> ($stable(mem_dout) && $stable(mem_addr) && mem_doe));

  assert_read_undriven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> !mem_doe);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_total_cycles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(xfer_cnt) == int'(xfer_cycles(act_cfg))));

endmodule

bind xmem_seq xmem_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .act_cfg  (act_cfg),
  .done     (done),
  .mem_addr (mem_addr),
  .mem_dout (mem_dout),
  .mem_doe  (mem_doe),
  .mem_rd_n (mem_rd_n),
  .mem_wr_n (mem_wr_n),
  .mem_ale  (mem_ale)
);

// File: tb/xmem_seq_tb.sv
`timescale 1ns/1ps
module xmem_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_mux = 1'b0;
  logic [1:0]  cfg_latch = '0, cfg_setup = '0, cfg_hold = '0;
  logic [3:0]  cfg_strobe = '0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        done;
  logic [7:0]  rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_dout;
  logic        mem_doe;
  logic [7:0]  mem_din = '0;
  logic        mem_rd_n, mem_wr_n, mem_ale;

  int n_chk = 0;
  int n_bad = 0;
  bit cur_mux = 1'b0;

  always #10 clk = ~clk;

  xmem_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mux(cfg_mux),
    .cfg_latch(cfg_latch), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
    .cfg_hold(cfg_hold), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_ale(mem_ale)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int total_of(bit mux, int s, int w, int h, int l);
    return 4 + s + (w + 1) + h + (mux ? (l + 2) : 0);
  endfunction

  function automatic logic [7:0] mem_word(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic set_cfg(input bit mux, input int l, input int s, input int w, input int h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mux = mux; cfg_latch = 2'(l);
    cfg_setup = 2'(s); cfg_strobe = 4'(w); cfg_hold = 2'(h);
    @(negedge clk);
    cfg_we = 1'b0;
    cur_mux = mux;
  endtask

  // One transfer; counts phase widths at negedges and checks pins and result.
  task automatic xfer(input bit we, input logic [15:0] addr, input logic [7:0] wd,
                      input int exp_total, input int exp_strb, input int exp_ale,
                      input bit mid_cfg, input bit spam, input string tag);
    int n = 0, strb = 0, ale = 0, pin_err = 0;
    logic [7:0]  lat_lo = '0;
    logic [15:0] bus_a;
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    forever begin
      @(negedge clk);
      n++;
      req = spam && (n >= 2) && (n <= 4);
      if (spam) begin req_we = !we; req_addr = ~addr; req_wdata = ~wd; end
      cfg_we = mid_cfg && (n == 2);
      if (mid_cfg && n == 2) begin
        cfg_mux = 1'b0; cfg_setup = 2'd3; cfg_strobe = 4'd7; cfg_hold = 2'd3;
      end
      if (mem_ale) begin
        ale++; lat_lo = mem_dout;
        if (!mem_doe || mem_addr[7:0] != 8'h00) pin_err++;
      end
      bus_a = cur_mux ? {mem_addr[15:8], lat_lo} : mem_addr;
      if (!mem_rd_n || !mem_wr_n) begin
        if (bus_a != addr) pin_err++;
        if (!mem_rd_n && !mem_wr_n) pin_err++;
      end
      if (!mem_wr_n) begin
        strb++;
        if (!we || !mem_doe || mem_dout != wd) pin_err++;
      end
      if (!mem_rd_n) begin
        if (we || mem_doe) pin_err++;
        mem_din = mem_word(bus_a) + 8'(strb);
        strb++;
      end
      if (done || n > 200) break;
    end
    req = 1'b0;
    if (mid_cfg) cur_mux = 1'b0;
    check(n == exp_total, {tag, " total cycles R2"}, n, exp_total);
    check(strb == exp_strb, {tag, " strobe width R3"}, strb, exp_strb);
    check(ale == exp_ale, {tag, " latch pulse R4/R5"}, ale, exp_ale);
    check(pin_err == 0, {tag, " bus pins R6/R7/R4"}, pin_err, 0);
    if (!we) check(rdata == mem_word(addr) + 8'(exp_strb - 1), {tag, " read data R7"},
                   rdata, mem_word(addr) + 8'(exp_strb - 1));
    @(negedge clk);
    check(!done, {tag, " done one cycle R8"}, done, 0);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_rd_n && mem_wr_n && !mem_ale && !done && !mem_doe, "reset pins R1",
          {mem_rd_n, mem_wr_n, mem_ale, done, mem_doe}, 5'b11000);
    rst_n = 1'b1;
    xfer(1'b0, 16'h1234, 8'h00, 26, 16, 0, 1'b0, 1'b0, "defaults R1");
  endtask

  task automatic test_plain;
    set_cfg(1'b0, 3, 0, 0, 0);
    xfer(1'b1, 16'hA5C3, 8'h3C, 5, 1, 0, 1'b0, 1'b0, "plain min write R2 R5 R6");
    xfer(1'b0, 16'h0081, 8'h00, 5, 1, 0, 1'b0, 1'b0, "plain min read R7");
    set_cfg(1'b0, 3, 2, 5, 1);
    xfer(1'b0, 16'h0F0F, 8'h00, total_of(0, 2, 5, 1, 0), 6, 0, 1'b0, 1'b0, "plain mixed read R2");
    xfer(1'b1, 16'h7E01, 8'hC9, total_of(0, 2, 5, 1, 0), 6, 0, 1'b0, 1'b0, "plain mixed write R6");
  endtask

  task automatic test_mux;
    set_cfg(1'b1, 0, 0, 0, 0);
    xfer(1'b1, 16'hBEEF, 8'h77, 7, 1, 1, 1'b0, 1'b0, "mux min write R4");
    set_cfg(1'b1, 2, 1, 3, 2);
    xfer(1'b0, 16'h4321, 8'h00, total_of(1, 1, 3, 2, 2), 4, 3, 1'b0, 1'b0, "mux read R4 R7");
    xfer(1'b1, 16'h9A56, 8'hE1, total_of(1, 1, 3, 2, 2), 4, 3, 1'b0, 1'b0, "mux write R4 R6");
  endtask

  task automatic test_cfg_mid;
    set_cfg(1'b0, 0, 1, 2, 0);
    xfer(1'b1, 16'h2468, 8'h5B, total_of(0, 1, 2, 0, 0), 3, 0, 1'b1, 1'b0, "cfg mid-transfer R9");
    xfer(1'b0, 16'h1357, 8'h00, total_of(0, 3, 7, 3, 0), 8, 0, 1'b0, 1'b0, "cfg next transfer R9");
  endtask

  task automatic test_busy_req;
    int extra = 0;
    xfer(1'b1, 16'h6C3A, 8'hA4, total_of(0, 3, 7, 3, 0), 8, 0, 1'b0, 1'b1, "busy req R10");
    repeat (8) begin
      @(negedge clk);
      if (!mem_rd_n || !mem_wr_n || done || mem_ale) extra++;
    end
    check(extra == 0, "busy req started nothing R10", extra, 0);
  endtask

  initial begin
    test_reset();
    test_plain();
    test_mux();
    test_cfg_mid();
    test_busy_req();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule